// File: doc/BRIEF.md
# Receive Address Filter and Descriptor Writer

This block sits behind the receive side of an Ethernet MAC. It takes the frame as a byte stream with valid and last, holds the whole frame in an internal buffer, and decides at the last byte whether to keep it. A frame is kept when reception is enabled, its destination address is the broadcast address or the programmed station address, and its length is within the programmed limit. A frame that fails any test disappears without a trace.

A kept frame goes to memory through a 32-bit request/ready master port. The block follows a linked list of three-word receive descriptors. Each descriptor holds a buffer address at +0, a size/flag word at +4 and a next-descriptor address at +8. It reads the flag word first. If the descriptor is marked empty, the block copies the frame into the buffer, writes back the length, announces the packet and moves to the next descriptor. If the descriptor is still owned by software, the block discards the frame, switches reception off and raises an overflow event. Software programs the block through a small write-only register port and sees the enable bit and the current descriptor pointer as outputs.

Top module: `rx_frame_writer`

## Requirements
- R1: A frame is stored only when the receive-enable bit (bit 0 written at offset 0x18C) is set at the frame's last byte. Otherwise no memory write and no event follow.
- R2: The frame-length limit (bits 15:0 written at offset 0x10) resets to 0x600. A frame of exactly that many bytes is stored. A frame one byte longer is dropped.
- R3: The first six bytes must all be 0xFF, or must equal the station address. Octets 1 to 4 are bits 31:24, 23:16, 15:8 and 7:0 written at offset 0x40. Octets 5 and 6 are bits 31:24 and 23:16 written at offset 0x44. A frame shorter than six bytes, or with any one octet different, is dropped.
- R4: A memory request keeps its address, write flag and write data unchanged until the cycle in which mem_ready is high. Frame byte k goes to bits 8*(k mod 4)+7 : 8*(k mod 4) of word k/4 of the buffer. Unused byte lanes of the final word are written as zero.
- R5: A descriptor whose size word (+4) has bit 31 set is empty. For an empty descriptor the frame is copied to the buffer at the address in word +0. The size word is then rewritten as the length in bits 10:0 with all other bits zero. pkt_done pulses for one cycle, and desc_ptr takes the address from word +8.
- R6: A descriptor whose bit 31 is clear leads to no buffer write and no size-word write. rx_enable drops, overflow pulses for one cycle in the same cycle as the drop, and desc_ptr is unchanged.
- R7: The pointer written at offset 0x190 has bits 1:0 forced to zero. Buffer and next addresses taken from descriptors also ignore bits 1:0. Every memory address is word aligned.
- R8: A frame dropped by R1, R2 or R3 leaves memory, desc_ptr, rx_enable and both events unchanged.
- R9: After reset, rx_enable is 0, desc_ptr is 0, mem_req is low and neither event is active.
- R10: A frame whose first byte arrives while a stored frame is still being written to memory is ignored in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte, destination address first |
| in_last | input | 1 | Marks the final byte of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Completes the current request |
| rx_enable | output | 1 | Current receive-enable bit |
| desc_ptr | output | 32 | Current descriptor address |
| pkt_done | output | 1 | One-cycle pulse per stored frame |
| overflow | output | 1 | One-cycle pulse when a descriptor was full |

## Verification
The accept decision is registered at the edge that takes the last byte. The first descriptor read is therefore requested in the following cycle. pkt_done, overflow, the rx_enable drop and the desc_ptr update all appear one edge after the completing handshake. Because memory stalls make the total latency depend on frame length, the bench does not sample these results at a fixed cycle. After each frame it waits a window sized from the frame length that exceeds the worst-case write time. Only then does it compare ports, event counts and the whole memory image against its behavioural model. Between frames it also compares rx_enable, desc_ptr and the event counts on every clock.

// File: rtl/rx_frame_writer.sv
module rx_frame_writer #(
  parameter int          BUF_WORDS = 512,
  parameter logic [15:0] LEN_RESET = 16'h0600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        rx_enable,
  output logic [31:0] desc_ptr,
  output logic        pkt_done,
  output logic        overflow
);
  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int WIDX_W    = $clog2(BUF_WORDS);
  localparam int LEN_W     = 11;
  localparam int LEN_CAP   = (BUF_BYTES > 2047) ? 2047 : BUF_BYTES;

  typedef enum logic [2:0] {S_IDLE, S_SIZE, S_BUF, S_DATA, S_DESC, S_NEXT} wstate_t;

  wstate_t           state;
  logic [15:0]       max_len;
  logic [31:0]       sta_hi, sta_lo;
  logic [15:0]       cnt;
  logic              hit_bc, hit_st, skip;
  logic [LEN_W-1:0]  flen;
  logic [31:0]       baddr;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       fbuf [BUF_WORDS];

  logic [7:0]  exp_oct;
  logic        take, in_hdr, bc_n, st_n, accept, at_last;
  logic [16:0] len_fin;
  logic [LEN_W-1:0]  flen_m1;
  logic [31:0] lane_mask;

  assign take    = in_valid && (state == S_IDLE) && !skip;
  assign in_hdr  = cnt < 16'd6;
  assign len_fin = {1'b0, cnt} + 17'd1;
  assign flen_m1 = flen - 1'b1;
  assign at_last = widx == flen_m1[WIDX_W+1:2];

  always_comb begin
    case (cnt[2:0])
      3'd0:    exp_oct = sta_hi[31:24];
      3'd1:    exp_oct = sta_hi[23:16];
      3'd2:    exp_oct = sta_hi[15:8];
      3'd3:    exp_oct = sta_hi[7:0];
      3'd4:    exp_oct = sta_lo[31:24];
      3'd5:    exp_oct = sta_lo[23:16];
      default: exp_oct = 8'h00;
    endcase
  end

  assign bc_n = in_hdr ? (((cnt == 16'd0) || hit_bc) && (in_data == 8'hFF)) : hit_bc;
  assign st_n = in_hdr ? (((cnt == 16'd0) || hit_st) && (in_data == exp_oct)) : hit_st;
  assign accept = rx_enable && (bc_n || st_n) && (len_fin >= 17'd6) &&
                  (len_fin <= {1'b0, max_len}) && (len_fin <= 17'(LEN_CAP));

  always_comb begin
    lane_mask = '1;
    if (at_last && flen[1:0] != 2'd0)
      for (int i = 0; i < 4; i++)
        lane_mask[8*i +: 8] = (i < int'(flen[1:0])) ? 8'hFF : 8'h00;
  end

  assign mem_req = state != S_IDLE;
  assign mem_we  = (state == S_DATA) || (state == S_DESC);

  always_comb begin
    case (state)
      S_SIZE, S_DESC: mem_addr = desc_ptr + 32'd4;
      S_BUF:          mem_addr = desc_ptr;
      S_DATA:         mem_addr = baddr + {{(30-WIDX_W){1'b0}}, widx, 2'b00};
      S_NEXT:         mem_addr = desc_ptr + 32'd8;
      default:        mem_addr = 32'd0;
    endcase
  end

  assign mem_wdata = (state == S_DATA) ? (fbuf[widx] & lane_mask)
                   : (state == S_DESC) ? {{(32-LEN_W){1'b0}}, flen}
                   : 32'd0;

  always_ff @(posedge clk)
    if (take && 32'(cnt) < BUF_BYTES)
      fbuf[cnt[WIDX_W+1:2]][8*cnt[1:0] +: 8] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      max_len   <= LEN_RESET;
      sta_hi    <= '0;
      sta_lo    <= '0;
      rx_enable <= 1'b0;
      desc_ptr  <= '0;
      cnt       <= '0;
      hit_bc    <= 1'b0;
      hit_st    <= 1'b0;
      skip      <= 1'b0;
      flen      <= '0;
      baddr     <= '0;
      widx      <= '0;
      pkt_done  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      overflow <= 1'b0;

      if (reg_wr)
        case (reg_addr)
          12'h010: max_len   <= reg_wdata[15:0];
          12'h040: sta_hi    <= reg_wdata;
          12'h044: sta_lo    <= reg_wdata;
          12'h18C: rx_enable <= reg_wdata[0];
          12'h190: desc_ptr  <= {reg_wdata[31:2], 2'b00};
          default: ;
        endcase

      if (in_valid && (state != S_IDLE || skip))
        skip <= !in_last;

      if (take) begin
        hit_bc <= bc_n;
        hit_st <= st_n;
        if (in_last) begin
          cnt <= '0;
          if (accept) begin
            flen  <= len_fin[LEN_W-1:0];
            state <= S_SIZE;
          end
        end else if (cnt != 16'hFFFF) begin
          cnt <= cnt + 16'd1;
        end
      end

      if (mem_ready)
        case (state)
          S_SIZE:
            if (mem_rdata[31]) state <= S_BUF;
            else begin
              state     <= S_IDLE;
              rx_enable <= 1'b0;
              overflow  <= 1'b1;
            end
          S_BUF: begin
            baddr <= {mem_rdata[31:2], 2'b00};
            widx  <= '0;
            state <= S_DATA;
          end
          S_DATA: begin
            widx <= widx + 1'b1;
            if (at_last) state <= S_DESC;
          end
          S_DESC: state <= S_NEXT;
          S_NEXT: begin
            desc_ptr <= {mem_rdata[31:2], 2'b00};
            pkt_done <= 1'b1;
            state    <= S_IDLE;
          end
          default: ;
        endcase
    end
  end
endmodule

// File: rtl/rx_frame_writer_chk.sv
module rx_frame_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        rx_enable,
  input logic        pkt_done,
  input logic        overflow
);
  AST_EVENTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && overflow)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R5
  AST_OVF_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !rx_enable); // R6
  AST_OVF_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !mem_req); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R4
endmodule

bind rx_frame_writer rx_frame_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .rx_enable(rx_enable), .pkt_done(pkt_done), .overflow(overflow)
);

// File: tb/rx_frame_writer_test.sv
module rx_frame_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_we, mem_ready, rx_enable, pkt_done, overflow;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, desc_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rx_enable(rx_enable),
    .desc_ptr(desc_ptr), .pkt_done(pkt_done), .overflow(overflow));

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] exp_mem [MEM_WORDS];
  logic [1:0]  rdy_cnt = '0;
  assign mem_ready = rdy_cnt != 2'd3;
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(negedge clk) rdy_cnt <= rdy_cnt + 2'd1;
  always @(posedge clk)
    if (mem_req && mem_we && mem_ready) mem[mem_addr[13:2]] <= mem_wdata;

  int checks = 0, errors = 0;
  int done_cnt = 0, ovf_cnt = 0, exp_done = 0, exp_ovf = 0;
  bit settled = 1'b0;
  bit m_en = 1'b0;
  logic [31:0] m_ptr = '0;
  int m_maxlen = 'h600;
  logic [47:0] m_sta = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    done_cnt += int'(pkt_done);
    ovf_cnt  += int'(overflow);
    if (settled) begin
      check(rx_enable == m_en, "R8 enable between frames", 32'(rx_enable), 32'(m_en));
      check(desc_ptr == m_ptr, "R8 pointer between frames", desc_ptr, m_ptr);
      check(done_cnt == exp_done && ovf_cnt == exp_ovf, "R8 no stray event",
            32'(done_cnt + ovf_cnt), 32'(exp_done + exp_ovf));
    end
  end

  task automatic put(input int addr, input logic [31:0] v);
    mem[addr >> 2] = v;
    exp_mem[addr >> 2] = v;
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    settled = 1'b0;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      12'h010: m_maxlen = int'(d[15:0]);
      12'h040: m_sta[47:16] = d;
      12'h044: m_sta[15:0] = d[31:16];
      12'h18C: m_en = d[0];
      12'h190: m_ptr = {d[31:2], 2'b00};
      default: ;
    endcase
    @(negedge clk);
    settled = 1'b1;
  endtask

  task automatic make_frame(input logic [47:0] dst, input int len, output logic [7:0] q[$]);
    q = {};
    for (int i = 0; i < len; i++)
      q.push_back(i < 6 ? dst[47 - 8*i -: 8] : 8'((i * 7 + len) & 255));
  endtask

  task automatic model_frame(input logic [7:0] q[$]);
    int len = q.size();
    bit bc = len >= 6, st = len >= 6;
    logic [31:0] sz, base;
    for (int i = 0; i < 6 && i < len; i++) begin
      if (q[i] != 8'hFF) bc = 1'b0;
      if (q[i] != m_sta[47 - 8*i -: 8]) st = 1'b0;
    end
    if (!m_en || !(bc || st) || len > m_maxlen || len > 2047) return;
    sz = exp_mem[(m_ptr + 4) >> 2];
    if (sz[31]) begin
      base = exp_mem[m_ptr >> 2] & 32'hFFFF_FFFC;
      for (int i = 0; i < len; i++)
        exp_mem[(base + i) >> 2][8*((base + i) % 4) +: 8] = q[i];
      for (int i = len; i % 4 != 0; i++)
        exp_mem[(base + i) >> 2][8*((base + i) % 4) +: 8] = 8'h00;
      exp_mem[(m_ptr + 4) >> 2] = 32'(len);
      m_ptr = exp_mem[(m_ptr + 8) >> 2] & 32'hFFFF_FFFC;
      exp_done++;
    end else begin
      m_en = 1'b0;
      exp_ovf++;
    end
  endtask

  task automatic drive(input logic [7:0] q[$]);
    foreach (q[i]) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = q[i]; in_last = (i == q.size() - 1);
    end
  endtask

  task automatic finish_and_check(input string req, input int wait_len);
    int bad = 0;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (wait_len / 2 + 60) @(negedge clk);
    check(rx_enable == m_en, req, 32'(rx_enable), 32'(m_en));
    check(desc_ptr == m_ptr, req, desc_ptr, m_ptr);
    check(done_cnt == exp_done, req, 32'(done_cnt), 32'(exp_done));
    check(ovf_cnt == exp_ovf, req, 32'(ovf_cnt), 32'(exp_ovf));
    for (int w = 0; w < MEM_WORDS; w++) if (mem[w] !== exp_mem[w]) bad++;
    check(bad == 0, req, 32'(bad), 32'd0);
    settled = 1'b1;
  endtask

  task automatic frame(input logic [47:0] dst, input int len, input string req);
    logic [7:0] q[$];
    settled = 1'b0;
    make_frame(dst, len, q);
    model_frame(q);
    drive(q);
    finish_and_check(req, len);
  endtask

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;

  initial begin
    for (int w = 0; w < MEM_WORDS; w++) put(w * 4, 32'hA5A5_0000 + 32'(w));
    put(32'h100, 32'h1000); put(32'h104, 32'h8000_0000); put(32'h108, 32'h110);
    put(32'h110, 32'h2003); put(32'h114, 32'h8000_0000); put(32'h118, 32'h122);
    put(32'h120, 32'h3000); put(32'h124, 32'h8000_0000); put(32'h128, 32'h130);
    put(32'h130, 32'h3400); put(32'h134, 32'h0000_0040); put(32'h138, 32'h140);
    put(32'h140, 32'h3800); put(32'h144, 32'h8000_0000); put(32'h148, 32'h150);
    put(32'h150, 32'h3C00); put(32'h154, 32'h8000_0000); put(32'h158, 32'h160);

    repeat (3) @(negedge clk);
    check(rx_enable == 1'b0, "R9 reset enable", 32'(rx_enable), 0);
    check(desc_ptr == 32'd0, "R9 reset pointer", desc_ptr, 0);
    check(mem_req == 1'b0, "R9 reset idle port", 32'(mem_req), 0);
    check(!pkt_done && !overflow, "R9 reset events", 32'({pkt_done, overflow}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    settled = 1'b1;

    reg_write(12'h040, 32'h0211_2233);
    reg_write(12'h044, 32'h4455_0000);
    reg_write(12'h190, 32'h0000_0102);
    check(desc_ptr == 32'h100, "R7 pointer low bits", desc_ptr, 32'h100);

    frame(STA, 64, "R1 disabled frame dropped");
    reg_write(12'h18C, 32'h1);
    frame(48'h02_11_22_33_44_56, 64, "R3 last octet mismatch dropped");
    frame(48'h03_11_22_33_44_55, 64, "R3 first octet mismatch dropped");
    frame(STA, 61, "R5 R4 station frame stored");
    frame(BC, 1536, "R2 R7 frame at default limit stored");
    frame(BC, 1537, "R2 R8 frame over limit dropped");
    frame(BC, 5, "R3 short frame dropped");

    begin
      logic [7:0] qa[$], qb[$];
      settled = 1'b0;
      make_frame(STA, 40, qa);
      make_frame(BC, 100, qb);
      model_frame(qa);
      drive(qa);
      drive(qb);
      finish_and_check("R10 frame during write ignored", 140);
    end

    frame(STA, 30, "R6 full descriptor overflow");
    check(mem[32'h134 >> 2] == 32'h40, "R6 size word untouched", mem[32'h134 >> 2], 32'h40);
    frame(STA, 30, "R1 frame after overflow dropped");

    reg_write(12'h010, 32'd100);
    reg_write(12'h190, 32'h0000_0141);
    reg_write(12'h18C, 32'h1);
    frame(BC, 100, "R2 frame equal to programmed limit stored");
    frame(BC, 101, "R2 frame above programmed limit dropped");

    settled = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    settled = 1'b0;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule